// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptor

This block sits between four external interrupt request lines and a processor's exception sequencer. Each cycle it decides whether one of the pending requests may interrupt the running code. The decision depends on the current 3-bit interrupt priority level and on whether the core is already running privileged handler code. When a request is accepted, the block reports which kind of exception won. A vector dispatcher can then form the handler address from that report. The block also signals that the error-code register must be cleared before dispatch.

Each source has its own ceiling on the priority level. A source is eligible only while the current level is at or below its ceiling. The device ceiling is the parameter `DEV_MAX_LEVEL`, and each higher source has a ceiling one step above the one below it. Among eligible sources the most urgent one wins. The eligibility test and the selection are combinational. The acceptance is registered, so the take strobe and the exception kind appear one clock after the inputs that caused them. The strobe is one cycle wide. The reported kind keeps its value between strobes.

Top module: `irq_level_gate`

## Requirements
- R1: While `priv_mode` is 1, no interrupt is taken: `take` is 0 in the following cycle, whatever the requests and level.
- R2: A device request (`req_dev`) is eligible only when `level` is 0, 1, 2 or 3.
- R3: A clock request (`req_clk`) is eligible only when `level` is 4 or lower.
- R4: An interprocessor request (`req_ipi`) is eligible only when `level` is 5 or lower.
- R5: A machine-check request (`req_mchk`) is eligible only when `level` is 6 or lower. At level 7 no request is taken.
- R6: When several eligible requests are pending, the winner is chosen in this order: machine check, then interprocessor, then clock, then device. `kind` encodes the winner as 1 = device, 2 = clock, 3 = interprocessor, 4 = machine check, and 0 = none since reset.
- R7: `clr_err` is 1 in exactly the cycles in which `take` is 1.
- R8: An eligible request sampled at a clock edge sets `take` for the one following cycle, provided `take` was 0 at that edge. `take` is never 1 in two consecutive cycles. `kind` changes only in a cycle where `take` is 1, and otherwise holds the last winner.
- R9: During synchronous active-low reset, `take`, `clr_err` and `kind` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_dev | input | 1 | Device interrupt request |
| req_clk | input | 1 | Interval-clock interrupt request |
| req_ipi | input | 1 | Interprocessor interrupt request |
| req_mchk | input | 1 | Machine-check interrupt request |
| level | input | 3 | Current interrupt priority level, 0..7 |
| priv_mode | input | 1 | 1 while privileged handler code runs |
| take | output | 1 | One-cycle strobe: an interrupt was accepted |
| kind | output | 3 | Winning exception kind (see R6) |
| clr_err | output | 1 | Clear the error-code register before dispatch |

## Verification
Two functions can fall in the same cycle: the level threshold, which may disqualify the most urgent pending request, and the priority selection among several requests. The bench provokes this by raising several request lines together while the level sits exactly at a ceiling, for example all four lines at level 5 or 6. It then judges from `kind` whether the winner is the most urgent source that is still eligible, rather than the most urgent source overall. A held request is also run against the one-cycle strobe rule. The bench checks that acceptance alternates with idle cycles and that `kind` does not move in between.

// File: rtl/irq_gate_pkg.sv
// Package: shared encodings for the priority-level interrupt acceptor.
// Assumes source index order device=0, clock=1, interprocessor=2, machine check=3.
package irq_gate_pkg;
    localparam int NUM_SRC = 4;
    localparam int KIND_W  = $clog2(NUM_SRC + 1);

    typedef enum logic [KIND_W-1:0] {
        EXC_NONE   = 3'd0,
        EXC_DEVICE = 3'd1,
        EXC_CLOCK  = 3'd2,
        EXC_IPI    = 3'd3,
        EXC_MCHECK = 3'd4
    } exc_kind_e;
endpackage

// File: rtl/irq_eligibility.sv
// Module: per-source eligibility against the current priority level.
// Source i is eligible when it requests, privileged mode is off and
// level <= DEV_MAX_LEVEL + i. Purely combinational.
module irq_eligibility #(
    parameter int NSRC          = 4,
    parameter int LEVEL_W       = 3,
    parameter int DEV_MAX_LEVEL = 3
) (
    input  logic [NSRC-1:0]    req,
    input  logic [LEVEL_W-1:0] level,
    input  logic               priv_mode,
    output logic [NSRC-1:0]    elig
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            localparam int CEIL = DEV_MAX_LEVEL + g;
            // Compare the level against this source's ceiling.
            always_comb begin
                elig[g] = req[g] && !priv_mode && (int'(level) <= CEIL);
            end
        end
    endgenerate
endmodule

// File: rtl/irq_priority_pick.sv
// Module: fixed-priority selector; the highest-indexed eligible source wins.
// Output kind is index+1, or 0 with hit low when nothing is eligible.
module irq_priority_pick #(
    parameter int NSRC   = 4,
    parameter int KIND_W = 3
) (
    input  logic [NSRC-1:0]   elig,
    output logic              hit,
    output logic [KIND_W-1:0] kind
);
    // Scan upward so that a later (more urgent) source overrides.
    always_comb begin
        hit  = 1'b0;
        kind = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i]) begin
                hit  = 1'b1;
                kind = KIND_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irq_take_stage.sv
// Module: registers the acceptance decision into a one-cycle strobe,
// an error-clear pulse and a held exception kind.
// Assumes hit/kind_in are settled before the clock edge.
module irq_take_stage #(
    parameter int KIND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [KIND_W-1:0] kind_in,
    output logic              take_q,
    output logic              clr_q,
    output logic [KIND_W-1:0] kind_q
);
    logic accept;

    // Accept only when no strobe is currently out.
    always_comb begin
        accept = hit && !take_q;
    end

    // Strobe register: one cycle per acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= accept;
    end

    // Error-code clear register, paired with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= accept;
    end

    // Kind register: loads on acceptance, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      kind_q <= '0;
        else if (accept) kind_q <= kind_in;
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q);

    // R8
    kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_q |-> $stable(kind_q));

    // R7
    clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q == take_q);
endmodule

// File: rtl/irq_level_gate.sv
// Module: top of the priority-level interrupt acceptor.
// Gathers the four request lines, tests each against its level ceiling,
// picks the most urgent and registers the acceptance.
// Assumes inputs are synchronous to clk.
module irq_level_gate #(
    parameter int LEVEL_W       = 3,
    parameter int DEV_MAX_LEVEL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_dev,
    input  logic               req_clk,
    input  logic               req_ipi,
    input  logic               req_mchk,
    input  logic [LEVEL_W-1:0] level,
    input  logic               priv_mode,
    output logic               take,
    output logic [2:0]         kind,
    output logic               clr_err
);
    import irq_gate_pkg::*;

    localparam int MCHK_MAX = DEV_MAX_LEVEL + NUM_SRC - 1;

    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] elig;
    logic               hit;
    logic [KIND_W-1:0]  pick_kind;
    logic [KIND_W-1:0]  kind_q;

    // Pack request lines in urgency order, least urgent at bit 0.
    always_comb begin
        req_vec = {req_mchk, req_ipi, req_clk, req_dev};
    end

    irq_eligibility #(
        .NSRC(NUM_SRC), .LEVEL_W(LEVEL_W), .DEV_MAX_LEVEL(DEV_MAX_LEVEL)
    ) u_elig (
        .req(req_vec), .level(level), .priv_mode(priv_mode), .elig(elig)
    );

    irq_priority_pick #(.NSRC(NUM_SRC), .KIND_W(KIND_W)) u_pick (
        .elig(elig), .hit(hit), .kind(pick_kind)
    );

    irq_take_stage #(.KIND_W(KIND_W)) u_take (
        .clk(clk), .rst_n(rst_n), .hit(hit), .kind_in(pick_kind),
        .take_q(take), .clr_q(clr_err), .kind_q(kind_q)
    );

    // Drive the exception kind port from the held register.
    always_comb begin
        kind = 3'(kind_q);
    end

    // R1
    priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_mode |=> !take);

    // R5
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) > MCHK_MAX) |=> !take);

    // R2
    device_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == 3'(EXC_DEVICE)) |-> (int'($past(level)) <= DEV_MAX_LEVEL));

    // R6
    mchk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take) && $past(req_mchk) && !$past(priv_mode)
         && (int'($past(level)) <= MCHK_MAX))
        |-> (take && kind == 3'(EXC_MCHECK)));
endmodule

// File: tb/irq_level_gate_test.sv
module irq_level_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_dev = 1'b0, req_clk = 1'b0, req_ipi = 1'b0, req_mchk = 1'b0;
    logic [2:0] level = 3'd0;
    logic       priv_mode = 1'b0;
    logic       take, clr_err;
    logic [2:0] kind;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [2:0] last_kind = 3'd0;

    always #5 clk = ~clk;

    irq_level_gate uut (
        .clk(clk), .rst_n(rst_n),
        .req_dev(req_dev), .req_clk(req_clk), .req_ipi(req_ipi), .req_mchk(req_mchk),
        .level(level), .priv_mode(priv_mode),
        .take(take), .kind(kind), .clr_err(clr_err)
    );

    // Vector: {priv, level[2:0], req{mchk,ipi,clk,dev}, exp_take, exp_kind[2:0]}
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        12'b0_000_0001_1_001, // R2 device at level 0
        12'b0_011_0001_1_001, // R2 device at its ceiling
        12'b0_100_0001_0_000, // R2 device above ceiling
        12'b0_100_0010_1_010, // R3 clock at its ceiling
        12'b0_101_0010_0_000, // R3 clock above ceiling
        12'b0_101_0100_1_011, // R4 ipi at its ceiling
        12'b0_110_0100_0_000, // R4 ipi above ceiling
        12'b0_110_1000_1_100, // R5 mchk at its ceiling
        12'b0_111_1000_0_000, // R5 level 7 blocks mchk
        12'b0_111_1111_0_000, // R5 level 7 blocks all
        12'b1_000_1111_0_000, // R1 privileged mode blocks all
        12'b0_000_1111_1_100, // R6 all pending: mchk
        12'b0_000_0111_1_011, // R6 ipi over clock/device
        12'b0_000_0011_1_010, // R6 clock over device
        12'b0_100_0011_1_010, // R6 device filtered, clock wins
        12'b0_101_0111_1_011, // R6 only ipi left eligible
        12'b0_110_0111_0_000, // R6 none eligible at level 6
        12'b0_010_0101_1_011, // R6 ipi over device
        12'b0_000_0000_0_000, // R8 no request, no take
        12'b1_000_0001_0_000  // R1 privileged, device blocked
    };

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic p, input logic [2:0] l, input logic [3:0] r);
        priv_mode = p; level = l;
        {req_mchk, req_ipi, req_clk, req_dev} = r;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        drive(1'b0, 3'd0, 4'b1111);
        @(negedge clk);
        check("R9 take in reset", {2'b0, take}, 3'd0);
        check("R9 clr_err in reset", {2'b0, clr_err}, 3'd0);
        check("R9 kind in reset", kind, 3'd0);
        drive(1'b0, 3'd0, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][11], VEC[i][10:8], VEC[i][7:4]);
            @(negedge clk);
            check($sformatf("vec%0d take", i), {2'b0, take}, {2'b0, VEC[i][3]});
            check($sformatf("vec%0d R7 clr_err", i), {2'b0, clr_err}, {2'b0, VEC[i][3]});
            if (VEC[i][3]) begin
                check($sformatf("vec%0d kind", i), kind, VEC[i][2:0]);
                last_kind = VEC[i][2:0];
            end else begin
                check($sformatf("vec%0d R8 kind held", i), kind, last_kind);
            end
            drive(1'b0, 3'd0, 4'b0000);
        end

        // R8: held request alternates take / idle, kind stays
        @(negedge clk);
        drive(1'b0, 3'd1, 4'b0010);
        @(negedge clk);
        check("R8 held first take", {2'b0, take}, 3'd1);
        check("R8 held first kind", kind, 3'd2);
        @(negedge clk);
        check("R8 no back-to-back take", {2'b0, take}, 3'd0);
        check("R8 kind held between", kind, 3'd2);
        check("R7 clr_err low between", {2'b0, clr_err}, 3'd0);
        @(negedge clk);
        check("R8 held second take", {2'b0, take}, 3'd1);

        // R6: request set changes while strobe is out; new winner next accept
        drive(1'b0, 3'd0, 4'b1001);
        @(negedge clk);
        check("R8 blocked after strobe", {2'b0, take}, 3'd0);
        check("R8 kind not yet updated", kind, 3'd2);
        @(negedge clk);
        check("R6 mchk over device", kind, 3'd4);
        check("R6 take for mchk", {2'b0, take}, 3'd1);

        // R1: entering privileged mode while requests persist
        drive(1'b1, 3'd0, 4'b1111);
        @(negedge clk);
        @(negedge clk);
        check("R1 privileged held", {2'b0, take}, 3'd0);
        check("R1 kind unchanged", kind, 3'd4);

        // R9: reset mid-run clears state
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 4'b0000);
        @(negedge clk);
        check("R9 kind after reset", kind, 3'd0);
        check("R9 take after reset", {2'b0, take}, 3'd0);

        finish_run();
    end
endmodule